// File: doc/BRIEF.md
# Streaming Burst Read Engine

This block turns one logical read of any length into a stream of bus-width words. A client gives it a start address and a byte count on a ready/valid request channel. The engine cuts that range into AXI4 INCR read bursts that never straddle a 4 KB page and never exceed a beat cap. It issues them on a rotating set of AXI IDs, so the memory system may return them out of order. A reorder buffer then puts the words back into ascending address order on a ready/valid output channel.

Only one logical read is active at a time. While it runs, the request channel is closed and the activity flag is raised. Every outstanding burst owns one reorder slot, taken in issue order. The output drains only the oldest slot. The number of slots sets the in-flight limit.

Top module: `dmard_reader`

## Requirements
- R1: A request is taken on a rising edge where `req_valid` and `req_ready` are both high. From the next cycle `in_progress` is high and `req_ready` is low.
- R2: `req_addr` and `req_len` are multiples of DATA_BYTES. Every burst starts on a DATA_BYTES-aligned address, uses INCR (`m_arburst` = 2'b01), and sets `m_arsize` = log2(DATA_BYTES), which is 3'd2 for 4-byte words.
- R3: The bursts of one request cover exactly `req_len` bytes from `req_addr`, whatever the length. `req_len`/DATA_BYTES words come out, and no burst is issued beyond that range.
- R4: Each burst carries min(bytes left, bytes to the next 4 KB boundary, MAX_BEATS×DATA_BYTES) bytes, with `m_arlen` = beats−1, so no burst crosses a 4 KB boundary. Address, length and ID hold steady while `m_arvalid` waits for `m_arready`.
- R5: Burst IDs rotate 0,1,…,N_IDS−1,0,… across bursts and across requests. An ID is not reissued until its previous burst has delivered its `m_rlast` beat.
- R6: At most N_SLOTS bursts are outstanding, counting from issue until their last word leaves the output.
- R7: `req_ready` stays low while a request is active, and a request offered then is ignored. `req_ready` rises one cycle after the edge that consumes the final word.
- R8: `in_progress` is high exactly while a request is active. With it low, neither `m_arvalid` nor `out_valid` is asserted.
- R9: Once `out_valid` is high, it stays high with `out_data` unchanged until a cycle with `out_ready` high.
- R10: Output words come out in ascending address order, even when bursts return out of order and interleaved across IDs.
- R11: A zero-length request is accepted. It keeps `in_progress` high for one cycle and produces neither bursts nor words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Engine idle, request can be taken |
| req_addr | input | ADDR_W | Start byte address |
| req_len | input | LEN_W | Length in bytes |
| m_arvalid | output | 1 | Read address valid |
| m_arready | input | 1 | Read address accepted |
| m_araddr | output | ADDR_W | Burst start address |
| m_arlen | output | 8 | Beats minus one |
| m_arsize | output | 3 | Bytes per beat, log2 |
| m_arburst | output | 2 | Burst type (INCR) |
| m_arid | output | ID_W | Burst ID |
| m_rvalid | input | 1 | Read data valid |
| m_rready | output | 1 | Read data accepted (always high) |
| m_rid | input | ID_W | ID of the returned beat |
| m_rdata | input | DATA_BYTES×8 | Returned beat |
| m_rlast | input | 1 | Last beat of a burst |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Consumer takes the word |
| out_data | output | DATA_BYTES×8 | Output word |
| in_progress | output | 1 | A request is active |

## Verification
The flag and the request channel respond one cycle after the accepting edge. The bench therefore checks `in_progress` high and `req_ready` low at the first falling edge after that edge. At the falling edge after the edge that consumes the last word, `in_progress` is still high. One falling edge later the engine must be idle, and a zero-length request must already be idle at its second falling edge. Burst addresses, lengths and IDs are read at the falling edge where the bench raises `m_arready`, which is half a cycle before the handshake. Each output word is checked against the memory model at the falling edge where the bench raises `out_ready`. The hold rule is checked at the next falling edge after any stall.

// File: rtl/dmard_pkg.sv
package dmard_pkg;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_ACTIVE = 1'b1
    } rd_state_t;

    localparam logic [1:0] BURST_INCR = 2'b01;
    localparam int PAGE_BYTES = 4096;
    localparam int PAGE_BITS  = 12;

    function automatic logic [2:0] size_code(input int nbytes);
        return 3'($clog2(nbytes));
    endfunction

endpackage

// File: rtl/dmard_burst_gen.sv
module dmard_burst_gen
    import dmard_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LEN_W      = 32,
    parameter int DATA_BYTES = 4,
    parameter int N_IDS      = 4,
    parameter int MAX_BEATS  = 256,
    localparam int OFF_W     = $clog2(DATA_BYTES),
    localparam int BEAT_W    = $clog2(MAX_BEATS) + 1,
    localparam int ID_W      = (N_IDS > 1) ? $clog2(N_IDS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [LEN_W-1:0]  start_len,
    input  logic              fire,
    output logic              want,
    output logic              drained,
    output logic [ADDR_W-1:0] bur_addr,
    output logic [BEAT_W-1:0] bur_beats,
    output logic [ID_W-1:0]   bur_id
);

    localparam logic [ID_W-1:0]  LAST_ID   = ID_W'(N_IDS - 1);
    localparam logic [LEN_W-1:0] CAP_BYTES = LEN_W'(MAX_BEATS * DATA_BYTES);

    logic [ADDR_W-1:0] cur_addr;
    logic [LEN_W-1:0]  rem;
    logic [ID_W-1:0]   id_ptr;
    logic [LEN_W-1:0]  to_page;
    logic [LEN_W-1:0]  pick;

    // Burst size: smallest of what is left, the page remainder and the cap.
    always_comb begin
        to_page = LEN_W'(PAGE_BYTES) - LEN_W'(cur_addr[PAGE_BITS-1:0]);
        pick    = rem;
        if (to_page < pick)   pick = to_page;
        if (CAP_BYTES < pick) pick = CAP_BYTES;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_addr <= '0;
            rem      <= '0;
            id_ptr   <= '0;
        end else if (start) begin
            cur_addr <= start_addr;
            rem      <= start_len;
        end else if (fire) begin
            cur_addr <= cur_addr + ADDR_W'(pick);
            rem      <= rem - pick;
            id_ptr   <= (id_ptr == LAST_ID) ? '0 : id_ptr + 1'b1;
        end
    end

    assign want      = (rem != '0);
    assign drained   = (rem == '0);
    assign bur_addr  = cur_addr;
    assign bur_beats = BEAT_W'(pick >> OFF_W);
    assign bur_id    = id_ptr;

endmodule

// File: rtl/dmard_rob.sv
module dmard_rob #(
    parameter int DATA_W    = 32,
    parameter int N_IDS     = 4,
    parameter int N_SLOTS   = 4,
    parameter int MAX_BEATS = 256,
    localparam int ID_W     = (N_IDS > 1) ? $clog2(N_IDS) : 1,
    localparam int SLOT_W   = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1,
    localparam int BEAT_W   = $clog2(MAX_BEATS) + 1,
    localparam int IDX_W    = $clog2(MAX_BEATS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              alloc,
    input  logic [ID_W-1:0]   alloc_id,
    input  logic [BEAT_W-1:0] alloc_beats,
    output logic              can_alloc,
    input  logic              r_valid,
    input  logic [ID_W-1:0]   r_id,
    input  logic [DATA_W-1:0] r_data,
    input  logic              r_last,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              empty
);

    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(N_SLOTS - 1);

    logic [DATA_W-1:0] store     [N_SLOTS][MAX_BEATS];
    logic              slot_live [N_SLOTS];
    logic [BEAT_W-1:0] slot_need [N_SLOTS];
    logic [BEAT_W-1:0] slot_got  [N_SLOTS];
    logic [SLOT_W-1:0] id_slot   [N_IDS];
    logic [N_IDS-1:0]  id_busy;
    logic [SLOT_W-1:0] head, tail, r_slot;
    logic [BEAT_W-1:0] rd_idx;
    logic              pop, pop_last;

    function automatic logic [SLOT_W-1:0] bump(input logic [SLOT_W-1:0] p);
        return (p == LAST_SLOT) ? '0 : p + 1'b1;
    endfunction

    assign can_alloc = !slot_live[tail] && !id_busy[alloc_id];
    assign r_slot    = id_slot[r_id];
    assign out_valid = slot_live[head] && (rd_idx < slot_got[head]);
    assign out_data  = store[head][rd_idx[IDX_W-1:0]];
    assign pop       = out_valid && out_ready;
    assign pop_last  = pop && ((rd_idx + 1'b1) == slot_need[head]);

    always_comb begin
        empty = 1'b1;
        for (int i = 0; i < N_SLOTS; i++)
            if (slot_live[i]) empty = 1'b0;
    end

    for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
        localparam logic [SLOT_W-1:0] SID = SLOT_W'(g);
        logic take, fill, drop;
        assign take = alloc && (tail == SID);
        assign fill = r_valid && (r_slot == SID);
        assign drop = pop_last && (head == SID);

        always_ff @(posedge clk) begin
            if (rst) begin
                slot_live[g] <= 1'b0;
                slot_need[g] <= '0;
                slot_got[g]  <= '0;
            end else if (take) begin
                slot_live[g] <= 1'b1;
                slot_need[g] <= alloc_beats;
                slot_got[g]  <= '0;
            end else begin
                if (drop) slot_live[g] <= 1'b0;
                if (fill) slot_got[g]  <= slot_got[g] + 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (fill) store[g][slot_got[g][IDX_W-1:0]] <= r_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            head    <= '0;
            tail    <= '0;
            rd_idx  <= '0;
            id_busy <= '0;
            for (int i = 0; i < N_IDS; i++) id_slot[i] <= '0;
        end else begin
            if (alloc) begin
                tail              <= bump(tail);
                id_busy[alloc_id] <= 1'b1;
                id_slot[alloc_id] <= tail;
            end
            if (r_valid && r_last) id_busy[r_id] <= 1'b0;
            if (pop_last) begin
                head   <= bump(head);
                rd_idx <= '0;
            end else if (pop) begin
                rd_idx <= rd_idx + 1'b1;
            end
        end
    end

endmodule

// File: rtl/dmard_reader.sv
module dmard_reader
    import dmard_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LEN_W      = 32,
    parameter int DATA_BYTES = 4,
    parameter int N_IDS      = 4,
    parameter int N_SLOTS    = 4,
    parameter int MAX_BEATS  = 256,
    localparam int DATA_W    = DATA_BYTES * 8,
    localparam int ID_W      = (N_IDS > 1) ? $clog2(N_IDS) : 1,
    localparam int BEAT_W    = $clog2(MAX_BEATS) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    output logic              m_arvalid,
    input  logic              m_arready,
    output logic [ADDR_W-1:0] m_araddr,
    output logic [7:0]        m_arlen,
    output logic [2:0]        m_arsize,
    output logic [1:0]        m_arburst,
    output logic [ID_W-1:0]   m_arid,
    input  logic              m_rvalid,
    output logic              m_rready,
    input  logic [ID_W-1:0]   m_rid,
    input  logic [DATA_W-1:0] m_rdata,
    input  logic              m_rlast,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              in_progress
);

    rd_state_t         state;
    logic              start, ar_fire;
    logic              bg_want, bg_drained, rob_can, rob_empty;
    logic [ADDR_W-1:0] bg_addr;
    logic [BEAT_W-1:0] bg_beats;
    logic [ID_W-1:0]   bg_id;

    assign req_ready   = (state == ST_IDLE);
    assign in_progress = (state == ST_ACTIVE);
    assign start       = req_valid && req_ready;
    assign m_arvalid   = bg_want && rob_can;
    assign ar_fire     = m_arvalid && m_arready;
    assign m_araddr    = bg_addr;
    assign m_arlen     = 8'(bg_beats - 1'b1);
    assign m_arsize    = size_code(DATA_BYTES);
    assign m_arburst   = BURST_INCR;
    assign m_arid      = bg_id;
    assign m_rready    = 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            case (state)
                ST_IDLE:   if (start) state <= ST_ACTIVE;
                ST_ACTIVE: if (bg_drained && rob_empty) state <= ST_IDLE;
                default:   state <= ST_IDLE;
            endcase
        end
    end

    dmard_burst_gen #(
        .ADDR_W(ADDR_W), .LEN_W(LEN_W), .DATA_BYTES(DATA_BYTES),
        .N_IDS(N_IDS), .MAX_BEATS(MAX_BEATS)
    ) u_gen (
        .clk(clk), .rst(rst),
        .start(start), .start_addr(req_addr), .start_len(req_len),
        .fire(ar_fire), .want(bg_want), .drained(bg_drained),
        .bur_addr(bg_addr), .bur_beats(bg_beats), .bur_id(bg_id)
    );

    dmard_rob #(
        .DATA_W(DATA_W), .N_IDS(N_IDS), .N_SLOTS(N_SLOTS), .MAX_BEATS(MAX_BEATS)
    ) u_rob (
        .clk(clk), .rst(rst),
        .alloc(ar_fire), .alloc_id(bg_id), .alloc_beats(bg_beats), .can_alloc(rob_can),
        .r_valid(m_rvalid), .r_id(m_rid), .r_data(m_rdata), .r_last(m_rlast),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .empty(rob_empty)
    );

endmodule

// File: rtl/dmard_reader_chk.sv
module dmard_reader_chk #(
    parameter int ADDR_W     = 32,
    parameter int DATA_BYTES = 4,
    parameter int ID_W       = 2,
    parameter int MAX_BEATS  = 256,
    localparam int DATA_W    = DATA_BYTES * 8
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              in_progress,
    input logic              m_arvalid,
    input logic              m_arready,
    input logic [ADDR_W-1:0] m_araddr,
    input logic [7:0]        m_arlen,
    input logic [ID_W-1:0]   m_arid,
    input logic              out_valid,
    input logic              out_ready,
    input logic [DATA_W-1:0] out_data
);

    AST_ACCEPT_CLOSES: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready |=> in_progress && !req_ready); // R1

    AST_AR_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        m_arvalid |-> (m_araddr % DATA_BYTES) == 0); // R2

    AST_PAGE_SAFE: assert property (@(posedge clk) disable iff (rst)
        m_arvalid |-> (int'(m_araddr[11:0]) + (int'(m_arlen) + 1) * DATA_BYTES) <= 4096); // R4

    AST_BEAT_CAP: assert property (@(posedge clk) disable iff (rst)
        m_arvalid |-> int'(m_arlen) < MAX_BEATS); // R4

    AST_AR_HOLD: assert property (@(posedge clk) disable iff (rst)
        m_arvalid && !m_arready |=> m_arvalid && $stable(m_araddr)
                                    && $stable(m_arlen) && $stable(m_arid)); // R4

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !in_progress |-> !m_arvalid && !out_valid); // R8

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_data)); // R9

endmodule

bind dmard_reader dmard_reader_chk #(
    .ADDR_W(ADDR_W), .DATA_BYTES(DATA_BYTES), .ID_W(ID_W), .MAX_BEATS(MAX_BEATS)
) u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .in_progress(in_progress), .m_arvalid(m_arvalid), .m_arready(m_arready),
    .m_araddr(m_araddr), .m_arlen(m_arlen), .m_arid(m_arid),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
);

// File: tb/dmard_reader_tb.sv
`timescale 1ns/1ps
module dmard_reader_tb_top;

    localparam int NV = 8;
    // {start address, length in bytes, expected burst count}
    localparam logic [95:0] VEC [NV] = '{
        {32'h0000_0100, 32'd64,   32'd1},
        {32'h0000_0FF8, 32'd32,   32'd2},
        {32'h0000_2000, 32'd5120, 32'd5},
        {32'h0001_0F00, 32'd2048, 32'd3},
        {32'h0000_3004, 32'd4,    32'd1},
        {32'h0000_5000, 32'd4096, 32'd4},
        {32'h0000_7FFC, 32'd8,    32'd2},
        {32'h0000_9C00, 32'd1024, 32'd1}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic [31:0] req_len = '0;
    logic        m_arvalid;
    logic        m_arready = 1'b0;
    logic [31:0] m_araddr;
    logic [7:0]  m_arlen;
    logic [2:0]  m_arsize;
    logic [1:0]  m_arburst;
    logic [1:0]  m_arid;
    logic        m_rvalid = 1'b0;
    logic        m_rready;
    logic [1:0]  m_rid = '0;
    logic [31:0] m_rdata = '0;
    logic        m_rlast = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [31:0] out_data;
    logic        in_progress;

    int chk_cnt = 0;
    int fail_cnt = 0;

    // expectation state
    logic [31:0] exp_ar_addr = '0;
    int          exp_ar_rem = 0;
    int          exp_id = 0;
    logic [31:0] exp_word_addr = '0;
    int          words_left = 0;
    int          bursts_seen = 0;
    int          outstanding = 0;
    int          bq_left [16];
    int          bq_head = 0;
    int          bq_tail = 0;
    logic [31:0] pend_addr [4];
    int          pend_left [4];
    logic        hold_chk = 1'b0;
    logic [31:0] hold_data = '0;

    always #10 clk = ~clk;

    dmard_reader dut_i (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_len(req_len),
        .m_arvalid(m_arvalid), .m_arready(m_arready), .m_araddr(m_araddr), .m_arlen(m_arlen),
        .m_arsize(m_arsize), .m_arburst(m_arburst), .m_arid(m_arid),
        .m_rvalid(m_rvalid), .m_rready(m_rready), .m_rid(m_rid), .m_rdata(m_rdata),
        .m_rlast(m_rlast), .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .in_progress(in_progress)
    );

    function automatic logic [31:0] mword(input logic [31:0] a);
        return (a * 32'h9E37_79B1) ^ 32'hC3A5_5A3C;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        chk_cnt++;
        if (!ok) begin
            fail_cnt++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", chk_cnt, fail_cnt);
        $finish;
    endtask

    // Slave, consumer and stream monitor; all decisions at the falling edge.
    always @(negedge clk) begin
        if (!rst) begin
            // consumer side
            if (hold_chk) begin
                chk(out_valid == 1'b1, "R9 valid held", {31'd0, out_valid}, 32'd1);
                chk(out_data == hold_data, "R9 data held", out_data, hold_data);
            end
            begin
                logic take;
                take = ($urandom % 4) != 0;
                out_ready = take;
                hold_chk  = out_valid && !take;
                hold_data = out_data;
                if (out_valid && take) begin
                    if (words_left == 0) begin
                        chk(1'b0, "R3 extra word", out_data, 32'd0);
                    end else begin
                        chk(out_data == mword(exp_word_addr), "R10 word order/data",
                            out_data, mword(exp_word_addr));
                        exp_word_addr += 4;
                        words_left--;
                        bq_left[bq_head]--;
                        if (bq_left[bq_head] == 0) begin
                            bq_head = (bq_head + 1) % 16;
                            outstanding--;
                        end
                    end
                end
            end
            // read data return, random ID choice
            m_rvalid = 1'b0;
            if (($urandom % 4) != 0) begin
                int base;
                base = $urandom % 4;
                for (int k = 0; k < 4; k++) begin
                    int id;
                    id = (base + k) % 4;
                    if (!m_rvalid && pend_left[id] != 0) begin
                        m_rvalid = 1'b1;
                        m_rid    = 2'(id);
                        m_rdata  = mword(pend_addr[id]);
                        m_rlast  = (pend_left[id] == 1);
                        pend_addr[id] += 4;
                        pend_left[id]--;
                    end
                end
            end
            // read address channel
            begin
                logic acc;
                acc = ($urandom % 3) != 0;
                m_arready = acc;
                if (m_arvalid && acc) begin
                    int bytes, topg;
                    if (exp_ar_rem == 0) begin
                        chk(1'b0, "R3 burst beyond range", m_araddr, 32'd0);
                    end else begin
                        bytes = exp_ar_rem;
                        topg  = 4096 - int'(exp_ar_addr[11:0]);
                        if (topg < bytes) bytes = topg;
                        if (1024 < bytes) bytes = 1024;
                        chk(m_araddr == exp_ar_addr, "R3 burst address", m_araddr, exp_ar_addr);
                        chk(int'(m_arlen) == bytes / 4 - 1, "R4 burst length",
                            {24'd0, m_arlen}, 32'(bytes / 4 - 1));
                        chk(int'(m_arid) == exp_id, "R5 id rotation", {30'd0, m_arid}, 32'(exp_id));
                        chk(m_arsize == 3'd2 && m_arburst == 2'b01, "R2 size/type",
                            {27'd0, m_arsize, m_arburst}, 32'h9);
                        chk(pend_left[m_arid] == 0, "R5 id reuse", 32'(pend_left[m_arid]), 32'd0);
                        chk(outstanding < 4, "R6 in-flight limit", 32'(outstanding + 1), 32'd4);
                        pend_addr[m_arid] = m_araddr;
                        pend_left[m_arid] = int'(m_arlen) + 1;
                        bq_left[bq_tail]  = int'(m_arlen) + 1;
                        bq_tail = (bq_tail + 1) % 16;
                        outstanding++;
                        exp_ar_addr += 32'(bytes);
                        exp_ar_rem  -= bytes;
                        exp_id = (exp_id + 1) % 4;
                        bursts_seen++;
                    end
                end
            end
        end
    end

    task automatic run_txn(input logic [31:0] a, input logic [31:0] l, input int nb);
        @(negedge clk);
        chk(req_ready == 1'b1, "R7 ready before request", {31'd0, req_ready}, 32'd1);
        exp_ar_addr   = a;
        exp_ar_rem    = int'(l);
        exp_word_addr = a;
        words_left    = int'(l) / 4;
        bursts_seen   = 0;
        req_valid = 1'b1;
        req_addr  = a;
        req_len   = l;
        @(negedge clk);
        chk(in_progress == 1'b1, "R1 in_progress after accept", {31'd0, in_progress}, 32'd1);
        chk(req_ready == 1'b0, "R7 ready low when active", {31'd0, req_ready}, 32'd0);
        // R7: a request offered while active must be ignored (large reads only)
        if (l >= 32'd1024) begin
            req_addr = 32'h00F0_0000;
            req_len  = 32'd16;
            repeat (3) @(negedge clk);
        end
        req_valid = 1'b0;
        wait (words_left == 0);
        @(negedge clk);
        chk(in_progress == 1'b1, "R8 active through last edge", {31'd0, in_progress}, 32'd1);
        @(negedge clk);
        chk(req_ready == 1'b1 && in_progress == 1'b0, "R7 idle after final word",
            {30'd0, req_ready, in_progress}, 32'h2);
        chk(bursts_seen == nb, "R4 burst count", 32'(bursts_seen), 32'(nb));
        chk(exp_ar_rem == 0, "R3 range covered", 32'(exp_ar_rem), 32'd0);
    endtask

    initial begin
        for (int i = 0; i < 4; i++) begin
            pend_left[i] = 0;
            pend_addr[i] = '0;
        end
        for (int i = 0; i < 16; i++) bq_left[i] = 0;
        repeat (4) @(negedge clk);
        chk(req_ready == 1'b1, "R7 reset ready", {31'd0, req_ready}, 32'd1);
        chk(in_progress == 1'b0, "R8 reset idle", {31'd0, in_progress}, 32'd0);
        chk(m_arvalid == 1'b0 && out_valid == 1'b0, "R8 reset quiet",
            {30'd0, m_arvalid, out_valid}, 32'd0);
        rst = 1'b0;

        for (int v = 0; v < NV; v++)
            run_txn(VEC[v][95:64], VEC[v][63:32], int'(VEC[v][31:0]));

        // R11: zero-length request
        @(negedge clk);
        exp_ar_rem = 0;
        words_left = 0;
        bursts_seen = 0;
        req_valid = 1'b1;
        req_addr  = 32'h0000_4000;
        req_len   = 32'd0;
        @(negedge clk);
        req_valid = 1'b0;
        chk(in_progress == 1'b1, "R11 zero length accepted", {31'd0, in_progress}, 32'd1);
        @(negedge clk);
        chk(in_progress == 1'b0 && req_ready == 1'b1, "R11 zero length ends",
            {30'd0, in_progress, req_ready}, 32'h1);
        repeat (4) @(negedge clk);
        chk(bursts_seen == 0, "R11 no bursts", 32'(bursts_seen), 32'd0);

        // back-to-back after the zero-length request; ID rotation continues
        run_txn(32'h0000_AFF0, 32'd48, 2);
        finish_up();
    end

    initial begin
        repeat (150000) @(posedge clk);
        fail_cnt++;
        $display("FAIL R3 watchdog: actual=timeout expected=completion");
        finish_up();
    end

endmodule